// File: doc/BRIEF.md
# Horizontal Blanking Generator with Shift-Clock Masking

This block produces a per-line horizontal blanking pulse and uses it to park a set of four horizontal shift clocks at fixed levels while the pulse is active. A pixel counter restarts on each rising edge of the line-sync input and then advances once per pixel clock. The pulse is shaped by one of several stored sequences. Each sequence holds two counter positions: blanking begins at the first and ends at the second. The pulse has no polarity setting of its own.

While blanking is active, the shift-clock outputs are forced into complementary pairs. A single polarity bit decides whether the odd-numbered clocks (H1, H3) sit low and the even-numbered ones (H2, H4) sit high, or the reverse. Outside the window, the free-running clock inputs reach the outputs combinationally, with no added delay. The sequence select is captured at each line start, so one sequence governs a whole line.

Top module: `hblank_mask_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, the pixel counter is 0, the captured sequence is 0 and no blanking state is stored. With the start positions set nonzero, `blank_o` is therefore 0 and `hclk_o` equals `hclk_i`.
- R2: A rising edge on `line_sync_i`, meaning high this cycle and low the cycle before, makes the counter 0 on the next cycle. Holding `line_sync_i` high longer does not restart it again.
- R3: `blank_o` rises in the same cycle that the counter equals the selected start position. It is low again in the cycle the counter equals the selected end position, and stays high in the cycles between.
- R4: When a sequence's start and end positions are equal, no blanking is produced on a line that uses it.
- R5: When the end position is below the start position, blanking runs from the start position until the next line start.
- R6: `seq_sel_i` is sampled only in the line-start cycle. A change in mid-line has no effect on `blank_o` until the following line.
- R7: With `mask_pol_i`=1 during blanking, `hclk_o` is 4'b1010, with bit 0 as H1 and bit 3 as H4: H1 and H3 low, H2 and H4 high.
- R8: With `mask_pol_i`=0 during blanking, `hclk_o` is 4'b0101. During blanking each even-numbered clock is always the complement of the odd-numbered clock before it.
- R9: When `blank_o` is 0, `hclk_o` equals `hclk_i` in the same cycle.
- R10: The counter saturates at its all-ones value and does not wrap. A start position of all ones therefore keeps blanking on until the next line start.
- R11: A line start clears any open blanking window. The new line's pulse depends only on its own positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync_i | input | 1 | Line-sync strobe; its rising edge starts a line |
| seq_sel_i | input | SELW | Sequence to use for the next line |
| tog_start_i | input | NSEQ x PW | Blanking start position of each sequence |
| tog_end_i | input | NSEQ x PW | Blanking end position of each sequence |
| mask_pol_i | input | 1 | Clock level selection during blanking |
| hclk_i | input | 4 | Free-running H1..H4 (bit 0 = H1) |
| blank_o | output | 1 | Horizontal blanking pulse, active high |
| hclk_o | output | 4 | Masked H1..H4 |

## Verification
The bench compares the design against a behavioural model on every pixel clock, across lines that use each of the four sequences. It targets equal toggle positions, where a design that ignored the rule would emit a one-cycle pulse. It also targets an end position below the start position, where a wrong design would stop blanking early or never start it. Other targets are a select changed in mid-line, which would make the pulse jump between sequences if sampled live, and a long line that reaches counter saturation, where a wrapping counter would end the window at the end position. Both mask polarities are checked against toggling clock inputs, so any swapped pair, stuck level or registered pass-through shows up at once.

// File: rtl/hblank_pkg.sv
package hblank_pkg;

    localparam int HCLK_N      = 4;
    localparam int DEF_POS_W   = 8;
    localparam int DEF_NUM_SEQ = 4;

    // Per-cycle decision of the window logic
    typedef struct packed {
        logic hit_start;
        logic hit_end;
        logic degenerate;
    } win_hits_t;

    // Parked level of the horizontal clocks: odd clocks take ~pol, even take pol
    function automatic logic [HCLK_N-1:0] park_levels(input logic pol);
        logic [HCLK_N-1:0] v;
        for (int i = 0; i < HCLK_N; i++) begin
            v[i] = (i % 2 == 0) ? ~pol : pol;
        end
        return v;
    endfunction

endpackage

// File: rtl/hb_line_counter.sv
module hb_line_counter #(
    parameter int PW = hblank_pkg::DEF_POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_sync,
    output logic          line_start,
    output logic [PW-1:0] cnt
);
    localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};

    logic sync_q;

    assign line_start = line_sync & ~sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            cnt    <= '0;
        end else begin
            sync_q <= line_sync;
            if (line_start)
                cnt <= '0;
            else if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        line_sync && !sync_q |=> cnt == '0);

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        !line_start && cnt != CNT_MAX |=> cnt == $past(cnt) + 1'b1);

    p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
        !line_start && cnt == CNT_MAX |=> cnt == CNT_MAX);

endmodule

// File: rtl/hb_seq_select.sv
module hb_seq_select #(
    parameter int PW   = hblank_pkg::DEF_POS_W,
    parameter int NSEQ = hblank_pkg::DEF_NUM_SEQ,
    localparam int SELW = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     line_start,
    input  logic [SELW-1:0]          seq_sel,
    input  logic [NSEQ-1:0][PW-1:0]  tog_start,
    input  logic [NSEQ-1:0][PW-1:0]  tog_end,
    output logic [PW-1:0]            cur_start,
    output logic [PW-1:0]            cur_end
);
    logic [SELW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (line_start)
            sel_q <= seq_sel;
    end

    // Out-of-range select values fall back to sequence 0
    always_comb begin
        cur_start = tog_start[0];
        cur_end   = tog_end[0];
        for (int s = 0; s < NSEQ; s++) begin
            if (sel_q == SELW'(s)) begin
                cur_start = tog_start[s];
                cur_end   = tog_end[s];
            end
        end
    end

    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(sel_q));

    p_sel_load_r6: assert property (@(posedge clk) disable iff (rst)
        line_start |=> sel_q == $past(seq_sel));

endmodule

// File: rtl/hb_window.sv
module hb_window #(
    parameter int PW = hblank_pkg::DEF_POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic [PW-1:0] cnt,
    input  logic [PW-1:0] cur_start,
    input  logic [PW-1:0] cur_end,
    output logic          blank
);
    import hblank_pkg::*;

    win_hits_t hits;
    logic      open_q;

    always_comb begin
        hits.hit_start  = (cnt == cur_start);
        hits.hit_end    = (cnt == cur_end);
        hits.degenerate = (cur_start == cur_end);
        blank = (hits.hit_start && !hits.degenerate) ||
                (open_q && !hits.hit_end);
    end

    always_ff @(posedge clk) begin
        if (rst || line_start)
            open_q <= 1'b0;
        else
            open_q <= blank;
    end

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        cnt == cur_start && cur_start != cur_end |-> blank);

    p_end_r3: assert property (@(posedge clk) disable iff (rst)
        cnt == cur_end |-> !blank);

    p_nopulse_r4: assert property (@(posedge clk) disable iff (rst)
        cur_start == cur_end && !open_q |-> !blank);

    p_line_clear_r11: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !open_q);

endmodule

// File: rtl/hb_clock_mask.sv
module hb_clock_mask (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          blank,
    input  logic                          pol,
    input  logic [hblank_pkg::HCLK_N-1:0] hclk_in,
    output logic [hblank_pkg::HCLK_N-1:0] hclk_out
);
    import hblank_pkg::*;

    logic [HCLK_N-1:0] parked;

    assign parked = park_levels(pol);

    for (genvar i = 0; i < HCLK_N; i++) begin : g_lane
        assign hclk_out[i] = blank ? parked[i] : hclk_in[i];
    end

    p_pass_r9: assert property (@(posedge clk) disable iff (rst)
        !blank |-> hclk_out == hclk_in);

    p_pol_high_r7: assert property (@(posedge clk) disable iff (rst)
        blank && pol |-> hclk_out == 4'b1010);

    p_pol_low_r8: assert property (@(posedge clk) disable iff (rst)
        blank && !pol |-> hclk_out == 4'b0101);

    p_pairs_r8: assert property (@(posedge clk) disable iff (rst)
        blank |-> (hclk_out[0] != hclk_out[1]) && (hclk_out[2] != hclk_out[3]));

endmodule

// File: rtl/hblank_mask_gen.sv
module hblank_mask_gen #(
    parameter int PW   = hblank_pkg::DEF_POS_W,
    parameter int NSEQ = hblank_pkg::DEF_NUM_SEQ,
    localparam int SELW = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    line_sync_i,
    input  logic [SELW-1:0]         seq_sel_i,
    input  logic [NSEQ-1:0][PW-1:0] tog_start_i,
    input  logic [NSEQ-1:0][PW-1:0] tog_end_i,
    input  logic                    mask_pol_i,
    input  logic [3:0]              hclk_i,
    output logic                    blank_o,
    output logic [3:0]              hclk_o
);
    logic          line_start;
    logic [PW-1:0] cnt;
    logic [PW-1:0] cur_start;
    logic [PW-1:0] cur_end;

    hb_line_counter #(.PW(PW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .line_sync  (line_sync_i),
        .line_start (line_start),
        .cnt        (cnt)
    );

    hb_seq_select #(.PW(PW), .NSEQ(NSEQ)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .seq_sel    (seq_sel_i),
        .tog_start  (tog_start_i),
        .tog_end    (tog_end_i),
        .cur_start  (cur_start),
        .cur_end    (cur_end)
    );

    hb_window #(.PW(PW)) u_win (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .cnt        (cnt),
        .cur_start  (cur_start),
        .cur_end    (cur_end),
        .blank      (blank_o)
    );

    hb_clock_mask u_mask (
        .clk      (clk),
        .rst      (rst),
        .blank    (blank_o),
        .pol      (mask_pol_i),
        .hclk_in  (hclk_i),
        .hclk_out (hclk_o)
    );

endmodule

// File: tb/tb_hblank_mask_gen.sv
module tb_hblank_mask_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 8;
    localparam int NSEQ = 4;
    localparam int CMAX = (1 << PW) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    line_sync = 1'b0;
    logic [1:0]              seq_sel = 2'd0;
    logic [NSEQ-1:0][PW-1:0] t_start;
    logic [NSEQ-1:0][PW-1:0] t_end;
    logic                    pol = 1'b1;
    logic [3:0]              hclk_in = 4'd0;
    logic                    blank_o;
    logic [3:0]              hclk_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int m_cnt = 0;
    bit m_prev = 0;
    bit m_open = 0;
    int m_sel = 0;

    hblank_mask_gen #(.PW(PW), .NSEQ(NSEQ)) dut (
        .clk         (clk),
        .rst         (rst),
        .line_sync_i (line_sync),
        .seq_sel_i   (seq_sel),
        .tog_start_i (t_start),
        .tog_end_i   (t_end),
        .mask_pol_i  (pol),
        .hclk_i      (hclk_in),
        .blank_o     (blank_o),
        .hclk_o      (hclk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // free-running horizontal clocks with varied patterns
    always @(posedge clk) begin
        #1;
        hclk_in = hclk_in + 4'd5;
    end

    // reference model and comparison, away from the active edge
    always @(negedge clk) begin
        bit       ls;
        bit       e_blank;
        logic [3:0] e_h;
        int       s, e;
        s  = int'(t_start[m_sel]);
        e  = int'(t_end[m_sel]);
        ls = line_sync && !m_prev;
        e_blank = (m_cnt == s && s != e) || (m_open && m_cnt != e);
        if (e_blank) e_h = pol ? 4'b1010 : 4'b0101;
        else         e_h = hclk_in;
        if (chk_en && !done) begin
            total++;
            if (blank_o !== e_blank) begin
                bad++;
                $display("FAIL %s blank_o actual=%b expected=%b cnt=%0d", cur_req, blank_o, e_blank, m_cnt);
            end
            total++;
            if (hclk_o !== e_h) begin
                bad++;
                $display("FAIL %s hclk_o actual=%b expected=%b", cur_req, hclk_o, e_h);
            end
        end
        if (rst) begin
            m_cnt = 0; m_prev = 0; m_open = 0; m_sel = 0;
        end else begin
            m_prev = line_sync;
            if (ls) begin
                m_cnt  = 0;
                m_open = 0;
                m_sel  = int'(seq_sel);
            end else begin
                if (m_cnt < CMAX) m_cnt = m_cnt + 1;
                m_open = e_blank;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_line(input int len);
        line_sync = 1'b1;
        step(1);
        line_sync = 1'b0;
        step(len - 1);
    endtask

    initial begin
        t_start[0] = 8'd5;   t_end[0] = 8'd12;
        t_start[1] = 8'd20;  t_end[1] = 8'd3;
        t_start[2] = 8'd7;   t_end[2] = 8'd7;
        t_start[3] = 8'd1;   t_end[3] = 8'd4;

        // R1: reset state
        step(3);
        chk_en = 1'b1;
        step(2);
        rst = 1'b0;
        total++;
        if (blank_o !== 1'b0 || hclk_o !== hclk_in) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=0/%b", blank_o, hclk_o, hclk_in);
        end
        step(3);

        // R2 / R3 / R7: basic lines with sequence 0, mask high
        cur_req = "R3"; pol = 1'b1; seq_sel = 2'd0;
        run_line(30);
        cur_req = "R7";
        run_line(25);

        // R2: sync held high restarts only once
        cur_req = "R2";
        line_sync = 1'b1;
        step(4);
        line_sync = 1'b0;
        step(20);

        // R8: mask low
        cur_req = "R8"; pol = 1'b0;
        run_line(25);

        // R4: equal positions
        cur_req = "R4"; seq_sel = 2'd2;
        run_line(2);
        run_line(30);

        // R5: end below start
        cur_req = "R5"; seq_sel = 2'd1; pol = 1'b1;
        run_line(2);
        run_line(40);

        // R11: new line cuts open window (seq1 still open at 40)
        cur_req = "R11"; seq_sel = 2'd3;
        run_line(10);
        run_line(10);

        // R6: mid-line change of select ignored
        cur_req = "R6"; seq_sel = 2'd0;
        run_line(2);
        line_sync = 1'b1; step(1); line_sync = 1'b0;
        step(3);
        seq_sel = 2'd1;
        step(26);

        // R9: pass-through with many clock patterns, blanking off lines
        cur_req = "R9"; seq_sel = 2'd2;
        run_line(2);
        run_line(20);

        // R10: saturation with start at all ones
        cur_req = "R10";
        t_start[3] = 8'hFF; t_end[3] = 8'hFE; seq_sel = 2'd3;
        run_line(2);
        run_line(300);
        total++;
        if (blank_o !== 1'b1) begin
            bad++;
            $display("FAIL R10 blank after saturation actual=%b expected=1", blank_o);
        end
        cur_req = "R11"; seq_sel = 2'd0;
        run_line(20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule